// File: doc/BRIEF.md
# Reset Sequencing Controller

This block builds the chip-wide reset. It has two sources: an active-low external reset pin and a watchdog reset request from inside the chip. The pin first passes through a spike filter that runs on a fast sampling clock. Only a low level that lasts longer than the filter window is treated as a reset. A filtered pin reset drives the PLL reset output, and the watchdog request never reaches that output. Both sources then share one internal path. That path clears the logic-domain flops asynchronously. It releases them synchronously to the core clock, and only while the PLL reports lock.

After release, a fixed initialization sequence of one machine cycle (12 core clocks) runs. Peripheral interrupts stay masked until it finishes, and the done flag tells the rest of the chip that bus activity may start. The block also drives the reset value of the port-direction vector. Every pin defaults to input except three, which default to outputs that carry the upper address lines. RAM contents are never touched by this block.

The sequencer is a three-state machine:
- SEQ_HOLD: the logic domain is held in reset. The asynchronous reset enters this state, and the machine moves to SEQ_INIT when the synchronized release arrives.
- SEQ_INIT: the machine counts sequence clocks. It moves to SEQ_RUN on the last count. It returns to SEQ_HOLD if the release is lost, for example on loss of lock.
- SEQ_RUN: normal operation. It returns to SEQ_HOLD if the release is lost.

Top module: `rst_seq_ctrl`

## Requirements
- R1: The pin reset is active low. When `pin_rst_n` stays low for at least FLT_TAPS consecutive `flt_clk` samples (16 samples at 5 ns by default, about 80 ns), `pll_rst` goes to 1 and `core_rst_n` goes to 0. While `pll_rst` is 1, `core_rst_n` is 0.
- R2: A low pulse on `pin_rst_n` shorter than 75 ns has no effect. `pll_rst` stays 0, and `core_rst_n` and `seq_done` stay 1.
- R3: When `wdt_req` is sampled 1 at a `clk` edge, `core_rst_n` drops to 0 right after that edge. `pll_rst` stays 0 throughout the watchdog reset.
- R4: While `pll_locked` is 0, `core_rst_n` stays 0. Once both reset sources are gone, `core_rst_n` rises on the third `clk` edge that samples `pll_locked` as 1.
- R5: `seq_done` rises exactly SEQ_LEN (12) `clk` edges after the edge on which `core_rst_n` rises. `seq_done` is 1 only while `core_rst_n` is 1.
- R6: If `pll_locked` drops, `core_rst_n` falls on the third `clk` edge after the drop. When lock returns, the sequence starts again from zero and takes a full SEQ_LEN clocks again.
- R7: `irq_gated` is all zeros while `seq_done` is 0. It equals `irq_raw` while `seq_done` is 1.
- R8: In `port_dir_default`, bit n gives the reset direction of pin n, with 1 meaning output. Bits 32, 33 and 36 are 1; they carry address lines 17, 18 and 19 in that order. All other bits are 0. The vector does not depend on the reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| flt_clk | input | 1 | Fast sampling clock for the pin filter |
| pin_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_req | input | 1 | Watchdog reset request, synchronous to clk |
| pll_locked | input | 1 | Clock-stable indication from the PLL |
| irq_raw | input | IRQ_W | Peripheral interrupt requests (ADC, ADC wake-up) |
| pll_rst | output | 1 | PLL reset, active high, pin source only |
| core_rst_n | output | 1 | Logic-domain reset, active low |
| seq_done | output | 1 | Initialization sequence complete |
| irq_gated | output | IRQ_W | Interrupt requests masked until seq_done |
| port_dir_default | output | PORT_W | Reset value of the port direction register |

## Verification
Each result is due a fixed number of cycles after its stimulus:
- `pll_rst` follows the pin within the filter window plus two synchronizer samples on `flt_clk`.
- `core_rst_n` falls right after the `clk` edge that samples `wdt_req`.
- `core_rst_n` rises on the third `clk` edge after lock returns, and falls on the third `clk` edge after lock is lost.
- `seq_done` rises twelve edges after `core_rst_n` rises.

The bench drives inputs on falling `clk` edges and samples on falling edges. It counts those edges one by one from the stimulus, so every check lands in the exact cycle the requirement names. Sticky monitors record any pulse on `pll_rst` or `core_rst_n` between checks, which lets rejected glitches and watchdog resets be judged at the ports.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_HOLD = 2'd0,
        SEQ_INIT = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/rst_pin_filter.sv
// Spike filter for the external reset pin, clocked by a fast sampling clock.
module rst_pin_filter #(
    parameter int TAPS = 16
) (
    input  logic flt_clk,
    input  logic pin_rst_n,
    output logic pin_rst
);
    localparam int CW = $clog2(TAPS + 1);

    logic         smp_a;
    logic         smp_b;
    logic [CW-1:0] low_cnt;

    // Two-sample capture of the asynchronous pin
    always_ff @(posedge flt_clk) begin
        smp_a <= pin_rst_n;
        smp_b <= smp_a;
    end

    // Count consecutive low samples; assert once TAPS have been seen
    always_ff @(posedge flt_clk) begin
        if (smp_b) begin
            low_cnt <= '0;
            pin_rst <= 1'b0;
        end else begin
            if (low_cnt < CW'(TAPS)) begin
                low_cnt <= low_cnt + 1'b1;
            end
            pin_rst <= (low_cnt >= CW'(TAPS - 1));
        end
    end

endmodule

// File: rtl/rst_sync.sv
// Asynchronous assert, synchronous deassert, gated by the lock indication.
module rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    input  logic lock,
    output logic release_q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain <= '0;
                else      chain <= lock;
            end
        end else begin : g_multi
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain <= '0;
                else      chain <= {chain[STAGES-2:0], lock};
            end
        end
    endgenerate

    assign release_q = chain[STAGES-1];

endmodule

// File: rtl/rst_seq_fsm.sv
// Post-release initialization sequencer.
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int SEQ_LEN = 12
) (
    input  logic clk,
    input  logic arst,
    input  logic release_q,
    output logic core_rst_n,
    output logic seq_done
);
    localparam int CW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(SEQ_LEN - 1);

    seq_state_e    state;
    seq_state_e    state_nx;
    logic [CW-1:0] seq_cnt;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_HOLD: if (release_q) state_nx = SEQ_INIT;
            SEQ_INIT: begin
                if (!release_q)            state_nx = SEQ_HOLD;
                else if (seq_cnt == LAST)  state_nx = SEQ_RUN;
            end
            SEQ_RUN:  if (!release_q) state_nx = SEQ_HOLD;
            default:  state_nx = SEQ_HOLD;
        endcase
    end

    // State register and sequence counter
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            state   <= SEQ_HOLD;
            seq_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state_nx == SEQ_INIT && state == SEQ_INIT) begin
                seq_cnt <= seq_cnt + 1'b1;
            end else begin
                seq_cnt <= '0;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        core_rst_n = 1'b0;
        seq_done   = 1'b0;
        unique case (state)
            SEQ_HOLD: begin core_rst_n = 1'b0; seq_done = 1'b0; end
            SEQ_INIT: begin core_rst_n = 1'b1; seq_done = 1'b0; end
            SEQ_RUN:  begin core_rst_n = 1'b1; seq_done = 1'b1; end
            default:  begin core_rst_n = 1'b0; seq_done = 1'b0; end
        endcase
    end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
    parameter int FLT_TAPS    = 16,
    parameter int SYNC_STAGES = 2,
    parameter int SEQ_LEN     = 12,
    parameter int IRQ_W       = 2,
    parameter int PORT_W      = 40,
    parameter int ADDR_PIN_A  = 32,
    parameter int ADDR_PIN_B  = 33,
    parameter int ADDR_PIN_C  = 36
) (
    input  logic              clk,
    input  logic              flt_clk,
    input  logic              pin_rst_n,
    input  logic              wdt_req,
    input  logic              pll_locked,
    input  logic [IRQ_W-1:0]  irq_raw,
    output logic              pll_rst,
    output logic              core_rst_n,
    output logic              seq_done,
    output logic [IRQ_W-1:0]  irq_gated,
    output logic [PORT_W-1:0] port_dir_default
);
    logic pin_rst;
    logic wdt_q;
    logic arst;
    logic release_q;

    rst_pin_filter #(.TAPS(FLT_TAPS)) u_filter (
        .flt_clk   (flt_clk),
        .pin_rst_n (pin_rst_n),
        .pin_rst   (pin_rst)
    );

    // Watchdog request registered so the shared reset path sees a clean level
    always_ff @(posedge clk) begin
        wdt_q <= wdt_req;
    end

    assign arst    = pin_rst | wdt_q;
    assign pll_rst = pin_rst;

    rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .arst      (arst),
        .lock      (pll_locked),
        .release_q (release_q)
    );

    rst_seq_fsm #(.SEQ_LEN(SEQ_LEN)) u_fsm (
        .clk        (clk),
        .arst       (arst),
        .release_q  (release_q),
        .core_rst_n (core_rst_n),
        .seq_done   (seq_done)
    );

    assign irq_gated = irq_raw & {IRQ_W{seq_done}};

    generate
        for (genvar i = 0; i < PORT_W; i++) begin : g_dir
            assign port_dir_default[i] = (i == ADDR_PIN_A) || (i == ADDR_PIN_B) || (i == ADDR_PIN_C);
        end
    endgenerate

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
    parameter int SEQ_LEN = 12,
    parameter int IRQ_W   = 2
) (
    input logic             clk,
    input logic             wdt_req,
    input logic             pll_rst,
    input logic             core_rst_n,
    input logic             seq_done,
    input logic [IRQ_W-1:0] irq_raw,
    input logic [IRQ_W-1:0] irq_gated
);
    logic live = 1'b0;
    int   run_cnt = 0;

    always_ff @(posedge clk) begin
        live <= 1'b1;
        if (!core_rst_n)    run_cnt <= 0;
        else if (!seq_done) run_cnt <= run_cnt + 1;
    end

    // R1
    pin_holds_core_chk: assert property (@(posedge clk) disable iff (!live)
        pll_rst |-> !core_rst_n);

    // R3
    wdt_resets_core_chk: assert property (@(posedge clk) disable iff (!live || pll_rst)
        wdt_req |=> !core_rst_n);

    // R5
    done_needs_core_chk: assert property (@(posedge clk) disable iff (!live)
        seq_done |-> core_rst_n);

    // R5
    release_not_done_chk: assert property (@(posedge clk) disable iff (!live || pll_rst)
        $rose(core_rst_n) |-> !seq_done);

    // R5
    seq_length_chk: assert property (@(posedge clk) disable iff (!live || pll_rst)
        $rose(seq_done) |-> (run_cnt == SEQ_LEN));

    // R7
    irq_mask_chk: assert property (@(posedge clk) disable iff (!live)
        !seq_done |-> (irq_gated == '0));

    // R7
    irq_pass_chk: assert property (@(posedge clk) disable iff (!live)
        seq_done |-> (irq_gated == irq_raw));

endmodule

bind rst_seq_ctrl rst_seq_chk #(.SEQ_LEN(SEQ_LEN), .IRQ_W(IRQ_W)) u_chk (
    .clk        (clk),
    .wdt_req    (wdt_req),
    .pll_rst    (pll_rst),
    .core_rst_n (core_rst_n),
    .seq_done   (seq_done),
    .irq_raw    (irq_raw),
    .irq_gated  (irq_gated)
);

// File: tb/sim_rst_seq_ctrl.sv
`timescale 1ns/1ps
module sim_rst_seq_ctrl;
    localparam int IRQ_W  = 2;
    localparam int PORT_W = 40;

    logic clk = 1'b0;
    logic flt_clk = 1'b0;
    logic pin_rst_n = 1'b0;
    logic wdt_req = 1'b0;
    logic pll_locked = 1'b0;
    logic [IRQ_W-1:0]  irq_raw = '0;
    logic              pll_rst;
    logic              core_rst_n;
    logic              seq_done;
    logic [IRQ_W-1:0]  irq_gated;
    logic [PORT_W-1:0] port_dir_default;

    always #10 clk = ~clk;
    always #2.5 flt_clk = ~flt_clk;

    rst_seq_ctrl u0 (
        .clk(clk), .flt_clk(flt_clk), .pin_rst_n(pin_rst_n), .wdt_req(wdt_req),
        .pll_locked(pll_locked), .irq_raw(irq_raw), .pll_rst(pll_rst),
        .core_rst_n(core_rst_n), .seq_done(seq_done), .irq_gated(irq_gated),
        .port_dir_default(port_dir_default)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic clr = 1'b1;
    logic pll_seen = 1'b0;
    logic core_low_seen = 1'b0;

    always @(posedge flt_clk) begin
        if (clr) pll_seen <= 1'b0;
        else if (pll_rst) pll_seen <= 1'b1;
    end

    always @(negedge clk) begin
        if (clr) core_low_seen <= 1'b0;
        else if (!core_rst_n) core_low_seen <= 1'b1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_seen();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    // Call with core_rst_n low: waits for release and counts edges to seq_done
    task automatic measure_seq(input string req);
        int g = 0;
        int t = 0;
        while (!core_rst_n && t < 500) begin
            @(negedge clk);
            t++;
        end
        chk(core_rst_n == 1'b1, req, core_rst_n, 1);
        chk(seq_done == 1'b0, req, seq_done, 0);
        while (!seq_done && g < 100) begin
            @(negedge clk);
            g++;
        end
        chk(g == 12, req, g, 12);
    endtask

    typedef struct packed {
        logic [15:0] low_ns;
        logic        hit;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{16'd20,  1'b0},
        '{16'd45,  1'b0},
        '{16'd70,  1'b0},
        '{16'd120, 1'b1},
        '{16'd60,  1'b0},
        '{16'd300, 1'b1}
    };

    logic [PORT_W-1:0] dir_exp;

    initial begin
        dir_exp = '0;
        dir_exp[32] = 1'b1;
        dir_exp[33] = 1'b1;
        dir_exp[36] = 1'b1;
        irq_raw = 2'b11;

        // Reset state with the pin held low
        repeat (40) @(negedge clk);
        chk(pll_rst == 1'b1, "R1 pll_rst at reset", pll_rst, 1);
        chk(core_rst_n == 1'b0, "R1 core_rst_n at reset", core_rst_n, 0);
        chk(seq_done == 1'b0, "R5 seq_done at reset", seq_done, 0);
        chk(irq_gated == 2'b00, "R7 irq masked at reset", irq_gated, 0);
        chk(port_dir_default == dir_exp, "R8 port dir at reset", port_dir_default, dir_exp);

        // Pin released, no lock yet
        pin_rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(pll_rst == 1'b0, "R1 pll_rst after pin high", pll_rst, 0);
        chk(core_rst_n == 1'b0, "R4 held without lock", core_rst_n, 0);

        // Lock arrives: release on the third edge
        pll_locked = 1'b1;
        @(negedge clk);
        chk(core_rst_n == 1'b0, "R4 edge1", core_rst_n, 0);
        @(negedge clk);
        chk(core_rst_n == 1'b0, "R4 edge2", core_rst_n, 0);
        @(negedge clk);
        chk(core_rst_n == 1'b1, "R4 edge3", core_rst_n, 1);
        begin
            int g = 0;
            while (!seq_done && g < 100) begin
                @(negedge clk);
                g++;
                if (g == 5) chk(irq_gated == 2'b00, "R7 irq masked in sequence", irq_gated, 0);
            end
            chk(g == 12, "R5 first sequence length", g, 12);
        end
        chk(irq_gated == 2'b11, "R7 irq passed after sequence", irq_gated, 3);
        irq_raw = 2'b10;
        @(negedge clk);
        chk(irq_gated == 2'b10, "R7 irq pattern 10", irq_gated, 2);
        chk(port_dir_default == dir_exp, "R8 port dir in run", port_dir_default, dir_exp);

        // Vector table: pin pulses of varying width
        for (int i = 0; i < 6; i++) begin
            clear_seen();
            pin_rst_n = 1'b0;
            #(VEC[i].low_ns);
            pin_rst_n = 1'b1;
            if (VEC[i].hit) begin
                measure_seq("R5 restart after pin reset");
                chk(pll_seen == 1'b1, "R1 long pulse resets pll", pll_seen, 1);
                chk(core_low_seen == 1'b1, "R1 long pulse resets core", core_low_seen, 1);
            end else begin
                repeat (10) @(negedge clk);
                chk(pll_seen == 1'b0, "R2 glitch pll_rst", pll_seen, 0);
                chk(core_low_seen == 1'b0, "R2 glitch core_rst_n", core_low_seen, 0);
                chk(seq_done == 1'b1, "R2 glitch seq_done", seq_done, 1);
            end
        end

        // Watchdog reset
        clear_seen();
        wdt_req = 1'b1;
        @(negedge clk);
        wdt_req = 1'b0;
        chk(core_rst_n == 1'b0, "R3 watchdog drops core", core_rst_n, 0);
        chk(seq_done == 1'b0, "R3 watchdog drops done", seq_done, 0);
        measure_seq("R5 restart after watchdog");
        chk(pll_seen == 1'b0, "R3 watchdog leaves pll_rst low", pll_seen, 0);

        // Lock loss in run
        pll_locked = 1'b0;
        @(negedge clk);
        chk(core_rst_n == 1'b1, "R6 lock loss edge1", core_rst_n, 1);
        @(negedge clk);
        chk(core_rst_n == 1'b1, "R6 lock loss edge2", core_rst_n, 1);
        @(negedge clk);
        chk(core_rst_n == 1'b0, "R6 lock loss edge3", core_rst_n, 0);
        pll_locked = 1'b1;
        measure_seq("R6 restart after lock loss");

        // Lock loss in the middle of the sequence
        pll_locked = 1'b0;
        repeat (4) @(negedge clk);
        pll_locked = 1'b1;
        while (!core_rst_n) @(negedge clk);
        repeat (5) @(negedge clk);
        pll_locked = 1'b0;
        repeat (4) @(negedge clk);
        chk(core_rst_n == 1'b0, "R6 mid-sequence lock loss", core_rst_n, 0);
        chk(seq_done == 1'b0, "R6 no done after abort", seq_done, 0);
        pll_locked = 1'b1;
        measure_seq("R6 full length after abort");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule